// File: doc/BRIEF.md
# Banked Data-Space Decoder with Program-Memory Window

This block decodes every access that a small 8-bit core makes to its 256-byte data space. A single request port carries a read or a write. Each access lands in one of four places: a local register file, the accumulator byte, a peripheral register strobe, or a read-only window that looks into a 12-bit program memory.

The local register file holds the four core pointer and short registers and 60 bytes of general RAM. The window covers 64 data addresses. It is positioned in 64-byte pages by a 6-bit bank register that can only be written. A window read becomes a program-memory fetch, and the fetched byte returns through the same response port as every other read.

Every read answers exactly one clock after its request, whatever it targets. The peripherals and the program memory lie outside the block. The block gives each peripheral register its own one-clock read or write select, and it receives a byte from program memory one clock after asserting a fetch.

Top module: `dspace_decoder`

## Requirements
- R1: A read of data address 40h..7Fh asserts `pm_req` in the request cycle with `pm_addr` = {bank[5:0], addr[5:0]}, and the response one clock later returns `pm_rdata`. For example, bank 28h and address 59h fetch program address A19h.
- R2: A write to C9h loads `req_wdata[5:0]` into the bank register and discards bits 7:6. Reset does not change the bank register.
- R3: After reset, every window response carries `rsp_undef`=1 until the bank register has been written once. From then on, window responses carry `rsp_undef`=0. Non-window responses always carry 0.
- R4: Addresses 80h..83h (the four core registers), 84h..BFh (60 RAM bytes) and FFh (the accumulator) store the written byte, and a read returns the last value written there.
- R5: Peripheral selects are one-hot per access and last only during the request cycle. The bit index of each register is: 0=C0h, 1=C1h, 2=C4h, 3=C5h, 4=C8h, 5=CCh, 6=CDh, 7=D0h, 8=D1h, 9=D2h, 10=D3h, 11=D4h, 12=D8h. A write raises `per_wr_sel`, and a read raises `per_rd_sel`. C8h is write-only and never raises a read select.
- R6: A read of a write-only location (C8h, C9h) or of any unmapped address returns FFh.
- R7: A write to the window or to an unmapped address raises no select, asserts no fetch, and leaves all stored contents unchanged.
- R8: `rsp_valid` rises exactly one clock after each read request. Writes and idle cycles produce no response.
- R9: A read of a peripheral address returns byte i of `per_rdata` (bits 8i+7..8i), where i is the index from R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Data-space address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock after the request |
| rsp_rdata | output | 8 | Read data |
| rsp_undef | output | 1 | Window read made before any bank write |
| pm_req | output | 1 | Program-memory fetch request |
| pm_addr | output | 12 | Program-memory address |
| pm_rdata | input | 8 | Program-memory byte, one clock after `pm_req` |
| per_rd_sel | output | 13 | One-hot peripheral read select |
| per_wr_sel | output | 13 | One-hot peripheral write select |
| per_wdata | output | 8 | Peripheral write data |
| per_rdata | input | 104 | Peripheral read bytes, byte i for select i |

## Verification
A vector table first writes distinct bytes to the register-file ends, the accumulator and a peripheral. It then reads back every region, including write-only and unmapped addresses. This separates the four destinations and shows that a wrong region decode returns a wrong byte or a stray select.

Window reads are tried in three states: before any bank write, after a bank write followed by a reset, and across all 64 banks at all 64 offsets. The first two states expose loss of the undefined flag or clearing of the bank on reset. The full sweep, with bits 7:6 of every bank write set, catches swapped, truncated or shifted address bits.

Writes into the window and into unmapped addresses are followed by read-backs of stored locations, which shows that those writes leave storage untouched.

// File: rtl/dspace_decoder.sv
module dspace_decoder #(
  parameter int DW     = 8,
  parameter int OFS_W  = 6,
  parameter int BANK_W = 6,
  parameter int NPER   = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [7:0]           req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_undef,
  output logic                 pm_req,
  output logic [BANK_W+OFS_W-1:0] pm_addr,
  input  logic [DW-1:0]        pm_rdata,
  output logic [NPER-1:0]      per_rd_sel,
  output logic [NPER-1:0]      per_wr_sel,
  output logic [DW-1:0]        per_wdata,
  input  logic [NPER*DW-1:0]   per_rdata
);

  localparam int RF_DEPTH = 1 << OFS_W;
  localparam logic [DW-1:0] OPEN_BYTE = '1;
  localparam logic [7:0] BANK_ADDR = 8'hC9;
  localparam logic [7:0] ACC_ADDR  = 8'hFF;
  localparam logic [1:0] WIN_PAGE  = 2'b01;
  localparam logic [1:0] RF_PAGE   = 2'b10;
  localparam logic [7:0] PER_ADDR [NPER] = '{8'hC0, 8'hC1, 8'hC4, 8'hC5, 8'hC8, 8'hCC,
                                             8'hCD, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD8};
  localparam logic [NPER-1:0] PER_WO = NPER'(16);

  logic rd, wr, in_win, in_rf, is_acc;
  assign rd     = req_valid & ~req_we;
  assign wr     = req_valid &  req_we;
  assign in_win = req_addr[7:6] == WIN_PAGE;
  assign in_rf  = req_addr[7:6] == RF_PAGE;
  assign is_acc = req_addr == ACC_ADDR;

  logic [BANK_W-1:0] bank;
  logic              bank_set;

  always_ff @(posedge clk)
    if (wr && req_addr == BANK_ADDR) bank <= req_wdata[BANK_W-1:0];

  always_ff @(posedge clk)
    if (!rst_n) bank_set <= 1'b0;
    else if (wr && req_addr == BANK_ADDR) bank_set <= 1'b1;

  assign pm_req  = rd & in_win;
  assign pm_addr = {bank, req_addr[OFS_W-1:0]};

  logic [NPER-1:0] hit;
  for (genvar g = 0; g < NPER; g++) begin : g_hit
    assign hit[g] = req_addr == PER_ADDR[g];
  end

  assign per_wr_sel = {NPER{wr}} & hit;
  assign per_rd_sel = {NPER{rd}} & hit & ~PER_WO;
  assign per_wdata  = req_wdata;

  logic [DW-1:0] rf [RF_DEPTH];
  logic [DW-1:0] acc;

  always_ff @(posedge clk) begin
    if (wr && in_rf)  rf[req_addr[OFS_W-1:0]] <= req_wdata;
    if (wr && is_acc) acc <= req_wdata;
  end

  logic [DW-1:0] rd_byte;
  always_comb begin
    rd_byte = OPEN_BYTE;
    if (in_rf)       rd_byte = rf[req_addr[OFS_W-1:0]];
    else if (is_acc) rd_byte = acc;
    else if (|per_rd_sel) begin
      rd_byte = '0;
      for (int i = 0; i < NPER; i++)
        if (per_rd_sel[i]) rd_byte = rd_byte | per_rdata[i*DW +: DW];
    end
  end

  logic          r_win;
  logic [DW-1:0] r_data;

  always_ff @(posedge clk)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      r_win     <= 1'b0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_valid <= rd;
      r_win     <= pm_req;
      rsp_undef <= pm_req & ~bank_set;
    end

  always_ff @(posedge clk)
    if (rd) r_data <= rd_byte;

  assign rsp_rdata = r_win ? pm_rdata : r_data;

endmodule

module dspace_decoder_chk #(
  parameter int DW     = 8,
  parameter int OFS_W  = 6,
  parameter int BANK_W = 6,
  parameter int NPER   = 13
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_we,
  input logic [7:0]           req_addr,
  input logic [DW-1:0]        req_wdata,
  input logic                 rsp_valid,
  input logic [DW-1:0]        rsp_rdata,
  input logic                 rsp_undef,
  input logic                 pm_req,
  input logic [BANK_W+OFS_W-1:0] pm_addr,
  input logic [DW-1:0]        pm_rdata,
  input logic [NPER-1:0]      per_rd_sel,
  input logic [NPER-1:0]      per_wr_sel,
  input logic [DW-1:0]        per_wdata,
  input logic [NPER*DW-1:0]   per_rdata
);

  assert_read_answers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_rd_sel, per_wr_sel}));

  assert_sel_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (per_rd_sel == '0 && per_wr_sel == '0));

  assert_fetch_only_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req |-> (req_valid && !req_we && req_addr[7:6] == 2'b01));

  assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && req_addr == 8'hC9) |=> pm_addr[BANK_W+OFS_W-1:OFS_W] == $past(req_wdata[BANK_W-1:0]));

  assert_undef_on_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_undef |-> rsp_valid);

  assert_write_only_reads_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && (req_addr == 8'hC8 || req_addr == 8'hC9)) |=> rsp_rdata == '1);

endmodule

bind dspace_decoder dspace_decoder_chk #(.DW(DW), .OFS_W(OFS_W), .BANK_W(BANK_W), .NPER(NPER)) chk_i (.*);

// File: tb/dspace_decoder_test.sv
`timescale 1ns/1ps
module dspace_decoder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [7:0]   req_addr = '0, req_wdata = '0;
  logic         rsp_valid, rsp_undef, pm_req;
  logic [7:0]   rsp_rdata, per_wdata;
  logic [11:0]  pm_addr;
  logic [7:0]   pm_rdata = '0;
  logic [12:0]  per_rd_sel, per_wr_sel;
  logic [103:0] per_rdata;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dspace_decoder uut (.*);

  function automatic logic [7:0] romf(input logic [11:0] a);
    return a[7:0] ^ {a[11:6], a[1:0]} ^ 8'h5A;
  endfunction

  always @(posedge clk) pm_rdata <= romf(pm_addr);

  initial for (int i = 0; i < 13; i++) per_rdata[i*8 +: 8] = 8'h30 + 8'(i);

  function automatic int per_idx(input logic [7:0] a);
    case (a)
      8'hC0: return 0;  8'hC1: return 1;  8'hC4: return 2;  8'hC5: return 3;
      8'hC8: return 4;  8'hCC: return 5;  8'hCD: return 6;  8'hD0: return 7;
      8'hD1: return 8;  8'hD2: return 9;  8'hD3: return 10; 8'hD4: return 11;
      8'hD8: return 12; default: return -1;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [12:0] s_rd, s_wr;
  logic        s_pm, c_valid, c_undef;
  logic [11:0] s_pma;
  logic [7:0]  c_data;

  task automatic access(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    s_rd = per_rd_sel; s_wr = per_wr_sel; s_pm = pm_req; s_pma = pm_addr;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    c_valid = rsp_valid; c_data = rsp_rdata; c_undef = rsp_undef;
  endtask

  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h80, 8'h11, 8'h00}, {1'b1, 8'h81, 8'h22, 8'h00}, {1'b1, 8'h82, 8'h33, 8'h00},
    {1'b1, 8'h83, 8'h44, 8'h00}, {1'b1, 8'h84, 8'h55, 8'h00}, {1'b1, 8'hBF, 8'h66, 8'h00},
    {1'b1, 8'hFF, 8'h77, 8'h00}, {1'b1, 8'hC0, 8'hAA, 8'h00}, {1'b1, 8'hC8, 8'hBB, 8'h00},
    {1'b0, 8'h80, 8'h00, 8'h11}, {1'b0, 8'h81, 8'h00, 8'h22}, {1'b0, 8'h82, 8'h00, 8'h33},
    {1'b0, 8'h83, 8'h00, 8'h44}, {1'b0, 8'h84, 8'h00, 8'h55}, {1'b0, 8'hBF, 8'h00, 8'h66},
    {1'b0, 8'hFF, 8'h00, 8'h77}, {1'b0, 8'hC8, 8'h00, 8'hFF}, {1'b0, 8'hC9, 8'h00, 8'hFF},
    {1'b0, 8'hC2, 8'h00, 8'hFF}, {1'b0, 8'hD5, 8'h00, 8'hFF}, {1'b0, 8'hC0, 8'h00, 8'h30},
    {1'b0, 8'hD8, 8'h00, 8'h3C}, {1'b0, 8'hD0, 8'h00, 8'h37}, {1'b1, 8'h44, 8'h99, 8'h00},
    {1'b1, 8'hC3, 8'h12, 8'h00}, {1'b0, 8'h84, 8'h00, 8'h55}
  };

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_undef == 1'b0, "R8 reset rsp", {rsp_valid, rsp_undef}, 0);
    check(pm_req == 1'b0 && per_rd_sel == '0 && per_wr_sel == '0, "R5 reset sel", {per_rd_sel, per_wr_sel}, 0);
    rst_n = 1'b1;

    access(1'b0, 8'h40, 8'h00);
    check(s_pm == 1'b1, "R1 fetch before bank", s_pm, 1);
    check(c_valid && c_undef, "R3 undef before bank write", {c_valid, c_undef}, 2'b11);

    for (int v = 0; v < NV; v++) begin
      logic we; logic [7:0] a, d, e; int k;
      {we, a, d, e} = VEC[v];
      k = per_idx(a);
      access(we, a, d);
      if (we) begin
        check(!c_valid, "R8 no rsp on write", c_valid, 0);
        check(s_wr == ((k >= 0) ? (13'd1 << k) : 13'd0) && s_rd == '0, "R5 write sel", s_wr, (k >= 0) ? (13'd1 << k) : 0);
        check(!s_pm, "R7 window write no fetch", s_pm, 0);
      end else begin
        check(c_valid, "R8 read rsp", c_valid, 1);
        check(c_data == e, "R4 R6 R9 read data", c_data, e);
        check(s_rd == ((k >= 0 && k != 4) ? (13'd1 << k) : 13'd0) && s_wr == '0, "R5 read sel", s_rd, 0);
      end
    end

    access(1'b1, 8'hC9, 8'hE8);
    check(s_wr == '0 && s_rd == '0, "R5 bank write no sel", s_wr, 0);
    access(1'b0, 8'h59, 8'h00);
    check(s_pma == 12'hA19, "R1 R2 bank 28h addr 59h", s_pma, 12'hA19);
    check(c_data == romf(12'hA19) && !c_undef, "R1 window data", c_data, romf(12'hA19));

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 8'h59, 8'h00);
    check(s_pma == 12'hA19, "R2 bank kept across reset", s_pma, 12'hA19);
    check(c_undef, "R3 undef after reset", c_undef, 1);

    for (int b = 0; b < 64; b++) begin
      access(1'b1, 8'hC9, 8'hC0 | 8'(b));
      for (int o = 0; o < 64; o++) begin
        logic [11:0] ea;
        ea = {6'(b), 6'(o)};
        access(1'b0, 8'h40 + 8'(o), 8'h00);
        check(s_pma == ea && c_data == romf(ea) && c_valid && !c_undef, "R1 R2 R3 sweep", {s_pma, c_data}, {ea, romf(ea)});
      end
    end

    access(1'b0, 8'hBF, 8'h00);
    check(c_data == 8'h66, "R7 storage intact", c_data, 8'h66);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule